// File: doc/BRIEF.md
# Chained Two-Level Interrupt Status Controller

This block collects single-cycle event pulses into two sticky status registers, a primary one and a secondary one. Each status register has a mask register of the same width, and bit n of a status register is governed by bit n of its mask. An event pulse sets its status bit only while the matching mask bit is enabled. The bit then stays set until the host reads that register. Reading a register clears it.

The secondary register's read image carries one extra bit, the chain bit, at position `W2`. It is high whenever the primary register holds an unmasked pending bit. A host that takes the interrupt reads the secondary register first. If the chain bit is clear, the cause is already in hand after that one read. If the chain bit is set, a second read of the primary register gives the rest. A single level-sensitive request line stays high while any unmasked status bit in either register is set.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset, both status registers and both mask registers are zero, `irq_o` is low, `rd_valid_o` is low, and reads of either register return zero.
- R2: An event pulse on bit n sets status bit n only when mask bit n of the same register is 1. An event on a masked bit leaves that status bit clear.
- R3: A set status bit stays set across idle cycles until its own register is read.
- R4: A read is requested by `rd_en_i`, with `rd_sel_i` = 0 selecting the primary register and 1 selecting the secondary. In the next cycle `rd_valid_o` is high and `rd_data_o` holds the register value from before the read. `rd_valid_o` is low in every cycle that does not follow a read.
- R5: A read clears every status bit of the addressed register only. The other register is left as it was.
- R6: An event that arrives in the same cycle as a read of its register is not lost. The read returns the old value, and the event's bit is set afterwards.
- R7: In a secondary read image, bits `W2-1:0` are the secondary status, bit `W2` is the chain bit (the OR of the primary register's set-and-unmasked bits), and any bits above are zero. The chain bit reads 0 once the primary register has been cleared.
- R8: `irq_o` is high exactly while some status bit is set and its mask bit is 1. Clearing a mask bit lowers the request even though the status bit remains set, and setting the mask bit again raises it.
- R9: A mask write (`wr_en_i`, `wr_sel_i` selecting the register, `wr_data_i` holding the value) takes effect from the next cycle. An event in the same cycle as the write is gated by the old mask.
- R10: Reading the secondary register does not alter the primary register, even though the read returns the chain bit derived from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_pri_i | input | W1 | Event pulses for the primary register |
| evt_sec_i | input | W2 | Event pulses for the secondary register |
| rd_en_i | input | 1 | Read request; clears the addressed register |
| rd_sel_i | input | 1 | Read target: 0 primary, 1 secondary |
| wr_en_i | input | 1 | Mask write request |
| wr_sel_i | input | 1 | Mask write target: 0 primary, 1 secondary |
| wr_data_i | input | DW | Mask write value, low bits used |
| rd_valid_o | output | 1 | Read data valid, one cycle after request |
| rd_data_o | output | DW | Read image of the addressed register |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with `W1` = 8 and `W2` = 5, so the read bus is 8 bits wide. With these values the chain bit sits at bit 5, in the middle of the bus, and the two bits above it must read zero. This also exercises the case where the two registers differ in width. Patterns such as 0xA5 and 0x13 in the masks let masked and unmasked bits interleave, so any shift between a status bit and its mask bit shows up in the read data.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    // Register select used for both reads and mask writes
    typedef enum logic {
        REG_PRI = 1'b0,
        REG_SEC = 1'b1
    } reg_sel_e;

    // Width of the shared read/write bus: wide enough for either image
    function automatic int bus_width(input int w_pri, input int w_sec);
        return (w_pri > w_sec + 1) ? w_pri : w_sec + 1;
    endfunction

endpackage

// File: rtl/irq_host_decode.sv
module irq_host_decode
    import irq_chain_pkg::*;
(
    input  logic rd_en_i,
    input  logic rd_sel_i,
    input  logic wr_en_i,
    input  logic wr_sel_i,
    output logic clr_pri_o,
    output logic clr_sec_o,
    output logic we_pri_o,
    output logic we_sec_o
);

    always_comb begin
        clr_pri_o = rd_en_i && (reg_sel_e'(rd_sel_i) == REG_PRI);
        clr_sec_o = rd_en_i && (reg_sel_e'(rd_sel_i) == REG_SEC);
        we_pri_o  = wr_en_i && (reg_sel_e'(wr_sel_i) == REG_PRI);
        we_sec_o  = wr_en_i && (reg_sel_e'(wr_sel_i) == REG_SEC);
    end

endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] evt_i,
    input  logic             clr_i,
    input  logic             mask_we_i,
    input  logic [WIDTH-1:0] mask_wdata_i,
    output logic [WIDTH-1:0] stat_o,
    output logic [WIDTH-1:0] mask_o,
    output logic             pend_o
);

    typedef struct packed {
        logic [WIDTH-1:0] stat;
        logic [WIDTH-1:0] mask;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (mask_we_i) begin
            bank_d.mask = mask_wdata_i;
        end
        // Clear and set in one step: a same-cycle event survives the clear
        bank_d.stat = (clr_i ? '0 : bank_q.stat) | (evt_i & bank_q.mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign stat_o = bank_q.stat;
    assign mask_o = bank_q.mask;
    assign pend_o = |(bank_q.stat & bank_q.mask);

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
    import irq_chain_pkg::*;
#(
    parameter int W1 = 16,
    parameter int W2 = 15,
    parameter int DW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          rd_en_i,
    input  logic          rd_sel_i,
    input  logic [W1-1:0] stat_pri_i,
    input  logic [W2-1:0] stat_sec_i,
    input  logic          chain_i,
    output logic          rd_valid_o,
    output logic [DW-1:0] rd_data_o
);

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [DW-1:0] img_pri, img_sec;

    always_comb begin
        img_pri = '0;
        img_pri[W1-1:0] = stat_pri_i;
        img_sec = '0;
        img_sec[W2-1:0] = stat_sec_i;
        img_sec[W2]     = chain_i;

        rd_d       = rd_q;
        rd_d.valid = rd_en_i;
        if (rd_en_i) begin
            rd_d.data = (reg_sel_e'(rd_sel_i) == REG_SEC) ? img_sec : img_pri;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid_o = rd_q.valid;
    assign rd_data_o  = rd_q.data;

endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
    import irq_chain_pkg::*;
#(
    parameter  int W1 = 16,
    parameter  int W2 = 15,
    localparam int DW = bus_width(W1, W2)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [W1-1:0] evt_pri_i,
    input  logic [W2-1:0] evt_sec_i,
    input  logic          rd_en_i,
    input  logic          rd_sel_i,
    input  logic          wr_en_i,
    input  logic          wr_sel_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          rd_valid_o,
    output logic [DW-1:0] rd_data_o,
    output logic          irq_o
);

    logic          clr_pri, clr_sec, we_pri, we_sec;
    logic [W1-1:0] s1_stat, s1_mask;
    logic [W2-1:0] s2_stat, s2_mask;
    logic          pend_pri, pend_sec;
    logic          chain_w;

    irq_host_decode u_decode (
        .rd_en_i  (rd_en_i),
        .rd_sel_i (rd_sel_i),
        .wr_en_i  (wr_en_i),
        .wr_sel_i (wr_sel_i),
        .clr_pri_o(clr_pri),
        .clr_sec_o(clr_sec),
        .we_pri_o (we_pri),
        .we_sec_o (we_sec)
    );

    irq_stat_bank #(.WIDTH(W1)) u_bank_pri (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .evt_i       (evt_pri_i),
        .clr_i       (clr_pri),
        .mask_we_i   (we_pri),
        .mask_wdata_i(wr_data_i[W1-1:0]),
        .stat_o      (s1_stat),
        .mask_o      (s1_mask),
        .pend_o      (pend_pri)
    );

    irq_stat_bank #(.WIDTH(W2)) u_bank_sec (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .evt_i       (evt_sec_i),
        .clr_i       (clr_sec),
        .mask_we_i   (we_sec),
        .mask_wdata_i(wr_data_i[W2-1:0]),
        .stat_o      (s2_stat),
        .mask_o      (s2_mask),
        .pend_o      (pend_sec)
    );

    // Chain bit summarises the primary register for the secondary image
    assign chain_w = pend_pri;

    irq_read_port #(.W1(W1), .W2(W2), .DW(DW)) u_read (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_en_i   (rd_en_i),
        .rd_sel_i  (rd_sel_i),
        .stat_pri_i(s1_stat),
        .stat_sec_i(s2_stat),
        .chain_i   (chain_w),
        .rd_valid_o(rd_valid_o),
        .rd_data_o (rd_data_o)
    );

    assign irq_o = pend_pri | pend_sec;

endmodule

// File: rtl/irq_chain_ctrl_chk.sv
module irq_chain_ctrl_chk
    import irq_chain_pkg::*;
#(
    parameter int W1 = 16,
    parameter int W2 = 15
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [W1-1:0] evt_pri_i,
    input logic          rd_en_i,
    input logic          rd_sel_i,
    input logic          wr_en_i,
    input logic          wr_sel_i,
    input logic          rd_valid_o,
    input logic          irq_o,
    input logic [W1-1:0] stat1_i,
    input logic [W1-1:0] mask1_i,
    input logic          chain_i
);

    logic rd_pri, rd_sec, wr_pri;
    assign rd_pri = rd_en_i && (rd_sel_i == REG_PRI);
    assign rd_sec = rd_en_i && (rd_sel_i == REG_SEC);
    assign wr_pri = wr_en_i && (wr_sel_i == REG_PRI);

    a_r1_reset_quiet: assert property (@(posedge clk_i)
        !rst_ni |=> (!irq_o && !rd_valid_o));

    a_r2_masked_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((stat1_i & ~$past(stat1_i) & ~$past(evt_pri_i & mask1_i)) == '0));

    a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_pri |=> ((stat1_i & $past(stat1_i)) == $past(stat1_i)));

    a_r4_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> rd_valid_o);

    a_r4_no_stray_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> !rd_valid_o);

    a_r7_chain_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_pri && (evt_pri_i == '0)) |=> !chain_i);

    a_r8_event_raises_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|(evt_pri_i & mask1_i)) && !wr_pri) |=> irq_o);

    a_r10_sec_read_keeps_pri: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_sec |=> ((stat1_i & $past(stat1_i)) == $past(stat1_i)));

endmodule

bind irq_chain_ctrl irq_chain_ctrl_chk #(.W1(W1), .W2(W2)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_pri_i (evt_pri_i),
    .rd_en_i   (rd_en_i),
    .rd_sel_i  (rd_sel_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .rd_valid_o(rd_valid_o),
    .irq_o     (irq_o),
    .stat1_i   (s1_stat),
    .mask1_i   (s1_mask),
    .chain_i   (chain_w)
);

// File: tb/irq_chain_ctrl_tb_top.sv
module irq_chain_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W1 = 8;
    localparam int W2 = 5;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W1-1:0] evt_pri = '0;
    logic [W2-1:0] evt_sec = '0;
    logic          rd_en = 1'b0, rd_sel = 1'b0;
    logic          wr_en = 1'b0, wr_sel = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_valid, irq;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int fails  = 0;

    // Requirement-level model state
    logic [W1-1:0] m_s1 = '0, m_m1 = '0;
    logic [W2-1:0] m_s2 = '0, m_m2 = '0;

    typedef struct {
        logic [DW-1:0] data;
        string         tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_chain_ctrl #(.W1(W1), .W2(W2)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .evt_pri_i (evt_pri),
        .evt_sec_i (evt_sec),
        .rd_en_i   (rd_en),
        .rd_sel_i  (rd_sel),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .rd_valid_o(rd_valid),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Driver: called at a falling edge, leaves the bench at the next falling edge
    task automatic step(input logic [W1-1:0] e1, input logic [W2-1:0] e2,
                        input logic rd, input logic rs,
                        input logic wr, input logic ws, input logic [DW-1:0] wd,
                        input string tag);
        logic [W1-1:0] n1;
        logic [W2-1:0] n2;
        logic          chain;
        logic          irq_exp;
        exp_t          item;
        evt_pri = e1; evt_sec = e2;
        rd_en = rd; rd_sel = rs;
        wr_en = wr; wr_sel = ws; wr_data = wd;
        if (rd) begin
            chain = |(m_s1 & m_m1);
            item.data = rs ? {2'b00, chain, m_s2} : m_s1;
            item.tag  = tag;
            exp_q.push_back(item);
        end
        n1 = ((rd && !rs) ? '0 : m_s1) | (e1 & m_m1);
        n2 = ((rd &&  rs) ? '0 : m_s2) | (e2 & m_m2);
        if (wr && !ws) m_m1 = wd;
        if (wr &&  ws) m_m2 = wd[W2-1:0];
        m_s1 = n1; m_s2 = n2;
        irq_exp = (|(m_s1 & m_m1)) | (|(m_s2 & m_m2));
        @(posedge clk);
        @(negedge clk);
        evt_pri = '0; evt_sec = '0; rd_en = 1'b0; wr_en = 1'b0;
        check(irq === irq_exp, tag, "irq", 32'(irq), 32'(irq_exp));
    endtask

    task automatic idle(input string tag);
        step('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic rd(input logic sel, input string tag);
        step('0, '0, 1'b1, sel, 1'b0, 1'b0, '0, tag);
    endtask

    // Monitor: pops expected read images as the design returns them
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", "unexpected rd_valid", 32'(rd_valid), 32'd0);
            end else begin
                exp_t item;
                item = exp_q.pop_front();
                check(rd_data === item.data, item.tag, "rd_data",
                      32'(rd_data), 32'(item.data));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(irq === 1'b0, "R1", "irq in reset", 32'(irq), 32'd0);
        check(rd_valid === 1'b0, "R1", "rd_valid in reset", 32'(rd_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq === 1'b0, "R1", "irq after reset", 32'(irq), 32'd0);
        rd(1'b0, "R1");
        rd(1'b1, "R1");

        // R2: all masks zero, events ignored
        step(8'hFF, 5'h1F, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R2");
        rd(1'b0, "R2");
        rd(1'b1, "R2");

        // R9: event in same cycle as mask write uses the old mask
        step(8'hFF, '0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, "R9");
        step('0, '0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h13, "R9");
        rd(1'b0, "R9");

        // R2, R7, R10: masked mix, chain bit, secondary read keeps primary
        step(8'h0F, 5'h0C, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R2");
        rd(1'b1, "R7");
        rd(1'b0, "R10");
        rd(1'b1, "R7");

        // R3: sticky across idle cycles
        step('0, 5'h03, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3");
        idle("R3");
        idle("R3");
        idle("R3");
        rd(1'b1, "R3");

        // R6: event during a read of the same register
        step(8'h80, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R6");
        step(8'h21, '0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R6");
        rd(1'b0, "R6");

        // R8: mask toggling gates the request without touching status
        step('0, 5'h10, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R8");
        step('0, '0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, "R8");
        idle("R8");
        step('0, '0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h13, "R8");
        rd(1'b1, "R8");

        // R5: read clears only the addressed register
        step(8'h01, 5'h01, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R5");
        rd(1'b0, "R5");
        rd(1'b0, "R5");
        rd(1'b1, "R5");

        idle("R4");
        idle("R4");
        check(exp_q.size() == 0, "R4", "reads left unanswered",
              32'(exp_q.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule